// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12) for Reed-Solomon datapaths. The field is represented as a quadratic extension over GF(2^6). Each operand is split into a 6-bit upper half and a 6-bit lower half. Three GF(64) products and one multiplication by a fixed GF(64) constant are then combined into the 12-bit result. The GF(64) arithmetic reduces by x^6 + x + 1.

A second mode, the alpha step, multiplies the first operand by the fixed primitive element 0xE01, and maps an input of zero to one. A syndrome or power-series generator can advance with this mode one step per operation, without supplying the constant. Each syndrome is a 12-bit value, and two of them sit in one 32-bit word, in bits 11:0 and 27:16. The operands of this block are single 12-bit elements.

The parameter `REGISTERED` picks the output form. With 1, the product and a valid strobe appear one clock after the input. With 0, the output is combinational and the strobe follows the input.

Top module: `gf4k_mult_top`

## Requirements
- R1: GF(64) products reduce by x^6 + x + 1. Whenever a doubling sets bit 6, bit 6 is cleared and 0x03 is XORed into the low bits.
- R2: In multiply mode (`mode_sel` = 0), result bits 11:6 equal G(ah^al, bh^bl) ^ G(al, bl). Here ah/al are `op_a` bits 11:6 / 5:0, bh/bl are the same halves of `op_b`, and G is the R1 product.
- R3: In multiply mode, result bits 5:0 equal G(G(ah, bh), 0x21) ^ G(al, bl).
- R4: In multiply mode, 0x001 is the identity and 0x000 annihilates: a·1 = a and a·0 = 0.
- R5: In alpha-step mode (`mode_sel` = 1), an `op_a` of zero gives 0x001.
- R6: In alpha-step mode, a nonzero `op_a` gives the R2/R3 product of `op_a` and 0xE01, and `op_b` has no effect on the result.
- R7: With `REGISTERED` = 1, `prod` and `out_valid` reflect the operation presented with `in_valid` high exactly one clock edge later. With `REGISTERED` = 0, `out_valid` equals `in_valid`.
- R8: While `rst` is high at a clock edge, the registered variant clears `out_valid` and `prod` to 0.
- R9: The multiply is commutative: swapping `op_a` and `op_b` gives the same result.
- R10: In the registered variant, a clock edge with `in_valid` low leaves `prod` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| mode_sel | input | 1 | 0: multiply op_a by op_b; 1: alpha step of op_a |
| op_a | input | 12 | First operand |
| op_b | input | 12 | Second operand (ignored in alpha-step mode) |
| prod | output | 12 | Field product |
| out_valid | output | 1 | Product is valid |

## Verification
The hardest case to reach is the set of operands whose GF(64) partial products need reduction in several of the unrolled stages at once, especially inside the constant multiply by 0x21 applied to the upper product. Uniform random 12-bit operands seldom line up the upper halves so that every reduction path is exercised together. The stimulus therefore mixes a fixed-seed random stream with directed operands whose halves are 0x3F, 0x20 or single high bits. It also sends swapped operand pairs and alpha steps with zero and all-ones inputs, each with random values on the ignored operand.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;

    localparam int HALF_W = 6;
    localparam int FULL_W = 2 * HALF_W;

    // low bits of x^6 + x + 1 (bit 6 is dropped by the shift)
    localparam logic [HALF_W-1:0] HALF_POLY_LO = 6'h03;
    // constant folded into the lower half of the tower product
    localparam logic [HALF_W-1:0] TOWER_K = 6'h21;
    // primitive element used by the alpha-step mode
    localparam logic [FULL_W-1:0] ALPHA_K = 12'hE01;
    localparam logic [FULL_W-1:0] FIELD_ONE = 12'h001;

    typedef enum logic {
        GF_MODE_MUL   = 1'b0,
        GF_MODE_ALPHA = 1'b1
    } gf_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } gf_elem_t;

    function automatic gf_elem_t join_halves(input logic [HALF_W-1:0] hi,
                                             input logic [HALF_W-1:0] lo);
        gf_elem_t e;
        e.hi = hi;
        e.lo = lo;
        return e;
    endfunction

endpackage

// File: rtl/gf64_mult.sv
module gf64_mult
    import gf4k_pkg::*;
#(
    parameter int              W    = HALF_W,
    parameter logic [W-1:0]    POLY = HALF_POLY_LO
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);

    // acc[i] : partial sum after bits 0..i-1 of a
    // sh[i]  : b times x^i, reduced
    logic [W-1:0] acc [W+1];
    logic [W-1:0] sh  [W];

    assign acc[0] = '0;
    assign sh[0]  = b;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign acc[i+1] = acc[i] ^ (a[i] ? sh[i] : '0);
        if (i < W - 1) begin : g_shift
            assign sh[i+1] = {sh[i][W-2:0], 1'b0} ^ (sh[i][W-1] ? POLY : '0);
        end
    end

    assign p = acc[W];

endmodule

// File: rtl/gf4k_tower_mult.sv
module gf4k_tower_mult
    import gf4k_pkg::*;
(
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    output logic [FULL_W-1:0] p
);

    localparam int N_DIRECT = 3;
    localparam int IDX_SUM  = 0;   // (ah^al)*(bh^bl)
    localparam int IDX_LOW  = 1;   // al*bl
    localparam int IDX_HIGH = 2;   // ah*bh

    gf_elem_t ea, eb, res;
    logic [HALF_W-1:0] xs [N_DIRECT];
    logic [HALF_W-1:0] ys [N_DIRECT];
    logic [HALF_W-1:0] pr [N_DIRECT];
    logic [HALF_W-1:0] high_k;

    assign ea = gf_elem_t'(a);
    assign eb = gf_elem_t'(b);

    assign xs[IDX_SUM]  = ea.hi ^ ea.lo;
    assign ys[IDX_SUM]  = eb.hi ^ eb.lo;
    assign xs[IDX_LOW]  = ea.lo;
    assign ys[IDX_LOW]  = eb.lo;
    assign xs[IDX_HIGH] = ea.hi;
    assign ys[IDX_HIGH] = eb.hi;

    for (genvar k = 0; k < N_DIRECT; k++) begin : g_prod
        gf64_mult #(.W(HALF_W), .POLY(HALF_POLY_LO)) u_mul (
            .a (xs[k]),
            .b (ys[k]),
            .p (pr[k])
        );
    end

    gf64_mult #(.W(HALF_W), .POLY(HALF_POLY_LO)) u_kmul (
        .a (pr[IDX_HIGH]),
        .b (TOWER_K),
        .p (high_k)
    );

    assign res = join_halves(pr[IDX_SUM] ^ pr[IDX_LOW], high_k ^ pr[IDX_LOW]);
    assign p   = FULL_W'(res);

endmodule

// File: rtl/gf4k_operand_sel.sv
module gf4k_operand_sel
    import gf4k_pkg::*;
(
    input  gf_mode_e          mode,
    input  logic [FULL_W-1:0] a_in,
    input  logic [FULL_W-1:0] b_in,
    output logic [FULL_W-1:0] x_out,
    output logic [FULL_W-1:0] y_out,
    output logic              force_one
);

    always_comb begin
        x_out     = a_in;
        y_out     = b_in;
        force_one = 1'b0;
        if (mode == GF_MODE_ALPHA) begin
            y_out     = ALPHA_K;
            force_one = (a_in == '0);
        end
    end

endmodule

// File: rtl/gf4k_mult_top.sv
module gf4k_mult_top
    import gf4k_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode_sel,
    input  logic [FULL_W-1:0] op_a,
    input  logic [FULL_W-1:0] op_b,
    output logic [FULL_W-1:0] prod,
    output logic              out_valid
);

    gf_mode_e          mode;
    logic [FULL_W-1:0] x, y, tower_p, result;
    logic              force_one;

    assign mode = gf_mode_e'(mode_sel);

    gf4k_operand_sel u_sel (
        .mode      (mode),
        .a_in      (op_a),
        .b_in      (op_b),
        .x_out     (x),
        .y_out     (y),
        .force_one (force_one)
    );

    gf4k_tower_mult u_tower (
        .a (x),
        .b (y),
        .p (tower_p)
    );

    assign result = force_one ? FIELD_ONE : tower_p;

    if (REGISTERED) begin : g_reg
        logic [FULL_W-1:0] prod_q;
        logic              vld_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) prod_q <= result;
            end
        end

        assign prod      = prod_q;
        assign out_valid = vld_q;

        AST_ALPHA_ZERO_ONE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode_sel && op_a == '0) |=> (prod == FIELD_ONE)); // R5
        AST_MUL_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !mode_sel && (op_a == '0 || op_b == '0)) |=> (prod == '0)); // R4
        AST_MUL_BY_ONE: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !mode_sel && op_b == FIELD_ONE) |=> (prod == $past(op_a))); // R4
        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid); // R7
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(prod) && !out_valid)); // R10
    end else begin : g_comb
        assign prod      = result;
        assign out_valid = in_valid;

        AST_COMB_VALID: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> out_valid); // R7
        AST_COMB_ALPHA_ZERO: assert property (@(posedge clk) disable iff (rst)
            (mode_sel && op_a == '0) |-> (prod == FIELD_ONE)); // R5
    end

endmodule

// File: tb/gf4k_mult_tb.sv
`timescale 1ns/1ps
module gf4k_mult_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        mode_sel = 1'b0;
    logic [11:0] op_a = '0;
    logic [11:0] op_b = '0;
    logic [11:0] prod;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gf4k_mult_top #(.REGISTERED(1'b1)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .mode_sel  (mode_sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .prod      (prod),
        .out_valid (out_valid)
    );

    // reference GF(64): multiply as polynomials, then reduce the top bits
    function automatic logic [5:0] ref64(input logic [5:0] a, input logic [5:0] b);
        logic [10:0] t = '0;
        for (int i = 0; i < 6; i++) if (b[i]) t ^= 11'(a) << i;
        for (int j = 10; j >= 6; j--) if (t[j]) t ^= 11'h043 << (j - 6);
        return t[5:0];
    endfunction

    function automatic logic [11:0] ref4k(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] ah = a[11:6], al = a[5:0], bh = b[11:6], bl = b[5:0];
        logic [5:0] lo_prod = ref64(al, bl);
        logic [5:0] hi = ref64(ah ^ al, bh ^ bl) ^ lo_prod;
        logic [5:0] lo = ref64(ref64(ah, bh), 6'h21) ^ lo_prod;
        return {hi, lo};
    endfunction

    function automatic logic [11:0] ref_alpha(input logic [11:0] a);
        return (a == 12'h000) ? 12'h001 : ref4k(a, 12'hE01);
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %03h expected %03h", req, act, exp);
        end
    endtask

    // present one operation, sample one edge later at the falling edge
    task automatic run_op(input string req, input logic m, input logic [11:0] a,
                          input logic [11:0] b);
        logic [11:0] exp = m ? ref_alpha(a) : ref4k(a, b);
        in_valid = 1'b1; mode_sel = m; op_a = a; op_b = b;
        @(negedge clk);
        check({req, " prod"}, prod, exp);
        check({req, " valid R7"}, {11'd0, out_valid}, 12'h001);
    endtask

    initial begin
        logic [11:0] last, p1, ra, rb;
        void'($urandom(32'h5EED_0101));
        repeat (3) @(negedge clk);
        check("R8 reset prod", prod, 12'h000);
        check("R8 reset valid", {11'd0, out_valid}, 12'h000);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle after reset", {11'd0, out_valid}, 12'h000);

        // R1: reductions through high bits of the halves
        run_op("R1 lo 0x20*0x20", 1'b0, 12'h020, 12'h020);
        run_op("R1 lo 0x3F*0x3F", 1'b0, 12'h03F, 12'h03F);
        run_op("R1 lo 0x21*0x2A", 1'b0, 12'h021, 12'h02A);
        // R2/R3: upper halves and mixed halves
        run_op("R2 hi 0x800*0x800", 1'b0, 12'h800, 12'h800);
        run_op("R3 0xFC0*0xFC0", 1'b0, 12'hFC0, 12'hFC0);
        run_op("R2 R3 0xFFF*0xFFF", 1'b0, 12'hFFF, 12'hFFF);
        run_op("R3 0x041*0x7C3", 1'b0, 12'h041, 12'h7C3);
        // R4 identity and zero
        run_op("R4 a*1", 1'b0, 12'hABC, 12'h001);
        check("R4 identity literal", prod, 12'hABC);
        run_op("R4 a*0", 1'b0, 12'hABC, 12'h000);
        check("R4 zero literal", prod, 12'h000);
        run_op("R4 0*b", 1'b0, 12'h000, 12'h5A5);
        // R5 alpha of zero with noise on op_b
        run_op("R5 alpha 0", 1'b1, 12'h000, 12'hFFF);
        check("R5 literal one", prod, 12'h001);
        // R6 alpha step, op_b ignored
        run_op("R6 alpha 1", 1'b1, 12'h001, 12'h123);
        check("R6 alpha of one is 0xE01", prod, 12'hE01);
        run_op("R6 alpha FFF", 1'b1, 12'hFFF, 12'h000);
        p1 = prod;
        run_op("R6 alpha FFF other b", 1'b1, 12'hFFF, 12'h777);
        check("R6 op_b has no effect", prod, p1);

        // R10 hold while idle
        last = prod;
        in_valid = 1'b0; op_a = 12'h3C3; op_b = 12'h5A5; mode_sel = 1'b0;
        @(negedge clk);
        check("R10 prod held", prod, last);
        check("R10 valid low", {11'd0, out_valid}, 12'h000);
        @(negedge clk);
        check("R10 prod held 2", prod, last);

        // random traffic with swapped pairs
        for (int k = 0; k < 1500; k++) begin
            ra = 12'($urandom);
            rb = 12'($urandom);
            if ($urandom_range(0, 7) == 0) ra[11:6] = 6'h3F;
            if ($urandom_range(0, 7) == 0) rb[5:0]  = 6'h20;
            if ($urandom_range(0, 3) == 0) begin
                run_op("R6 random alpha", 1'b1, ra, rb);
            end else begin
                run_op("R2 R3 random", 1'b0, ra, rb);
                p1 = prod;
                run_op("R9 swapped", 1'b0, rb, ra);
                check("R9 commutes", prod, p1);
            end
        end

        // R8 reset in mid-stream
        run_op("R7 before reset", 1'b0, 12'h123, 12'h456);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R8 mid reset prod", prod, 12'h000);
        check("R8 mid reset valid", {11'd0, out_valid}, 12'h000);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule